// File: doc/BRIEF.md
# Windowed link control engine

This block is the reliable-delivery layer of a point-to-point serial debug link. It sits between a client that hands over and receives fixed-width payloads and a framer/deframer that moves whole frames, each one a single control byte followed by an optional payload. Byte stuffing, CRC and the line itself are handled below this block. Payload meaning is handled above it.

The engine numbers outgoing information frames modulo eight. It keeps up to seven of them in a replay store until the peer acknowledges them. It resends from the oldest unacknowledged frame when no acknowledgement progress is seen within a timeout. It declares the link failed once the allowed number of resends has been used. On the receive side it accepts frames only in sequence and acknowledges them. The acknowledgement travels inside an outgoing information frame when one is ready, and in a receiver-ready supervisory frame otherwise. A receiver-not-ready frame tells the peer to stop when local buffers run out, and a receiver-ready frame reopens the window once they return. The connection comes up when either side sends an initialize request; the other side answers with an unnumbered acknowledge.

Top module: `lce_link_ctrl`

## Requirements
- R1: Information control bytes are laid out as nr in bits [7:5], ns in bits [4:2], bit 1 unused and bit 0 = 0. The block sends bit 1 as 0 and ignores its value on receipt.
- R2: Supervisory control bytes are laid out as nr in bits [7:5], bit 4 unused, type in bits [3:2] (ready = 00, not-ready = 01) and bits [1:0] = 01. The block sends bit 4 as 0 and ignores it on receipt.
- R3: Unnumbered control bytes carry bits [1:0] = 11 and a type in bits [7:3] (initialize = 00001, acknowledge = 00110); bit 2 is sent as 0 and ignored on receipt. A pulse on `open_req` while the link is down sends initialize (0x0B). An acknowledge received while one is awaited raises `link_up`. A received initialize raises `link_up` and is answered with acknowledge (0x33). Opening restarts every sequence number at 0.
- R4: Payloads accepted on the upper transmit handshake leave as information frames in acceptance order. ns starts at 0 and advances by one modulo eight per frame. nr always carries the count of in-order payloads received, modulo eight.
- R5: `up_tx_ready` is high only while the link is up and fewer than seven frames are unacknowledged. A received nr releases all frames before it, so no frame it covers is ever resent.
- R6: An information frame whose ns equals the expected value is delivered on `up_rx_valid`/`up_rx_data` one cycle later while `bufs_avail` is high. It is then acknowledged, in a ready frame if no information frame is waiting.
- R7: An information frame with an unexpected ns is not delivered and is answered with a ready frame carrying the unchanged expected nr.
- R8: An in-sequence information frame arriving while `bufs_avail` is low is dropped and answered with a not-ready frame. A ready frame follows once `bufs_avail` returns high.
- R9: After the peer sends not-ready, no information frame is offered until the peer sends ready.
- R10: If frames are unacknowledged for TIMEOUT cycles without acknowledgement progress, transmission restarts from the oldest one. The timer is frozen while the peer is not ready.
- R11: After MAX_RETRY restarts, the next timeout raises `link_fail` and lowers `link_up`. No further information or supervisory frame is sent until the link reopens.
- R12: While the link is down, received information and supervisory frames are ignored: nothing is delivered or acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Pulse to start a connection from this side |
| bufs_avail | input | 1 | Local receiver has room for a payload |
| up_tx_valid | input | 1 | Client offers a payload |
| up_tx_ready | output | 1 | Engine accepts the offered payload |
| up_tx_data | input | PAYLOAD_W | Payload to send |
| up_rx_valid | output | 1 | One-cycle pulse: received payload delivered |
| up_rx_data | output | PAYLOAD_W | Received payload |
| dn_tx_valid | output | 1 | Frame offered to the framer |
| dn_tx_ready | input | 1 | Framer takes the frame |
| dn_tx_ctrl | output | 8 | Control byte of the offered frame |
| dn_tx_payload | output | PAYLOAD_W | Payload of an offered information frame, zero otherwise |
| dn_rx_valid | input | 1 | Deframer presents a frame for one cycle |
| dn_rx_ctrl | input | 8 | Control byte of the received frame |
| dn_rx_payload | input | PAYLOAD_W | Payload of the received frame |
| link_up | output | 1 | Connection open |
| link_fail | output | 1 | Resend budget exhausted |

## Verification
The hardest state to reach is retry exhaustion. It needs one frame left unacknowledged through several full timeout periods, and a peer busy phase must not leave the timer running. The bench gets there by first sending a not-ready frame, checking that nothing is offered, then releasing with a ready frame and withholding every acknowledgement. It measures the gap before each resend, then waits for the failure flag and reopens with an initialize that has its ignored bit set. Random phases then walk ns and nr through the modulo-eight wrap, fill the window to seven, and mix deliveries with piggybacked acknowledgements.

// File: rtl/lce_pkg.sv
package lce_pkg;

    localparam int SEQ_W = 3;
    localparam int SEQ_N = 1 << SEQ_W;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef enum logic [1:0] {
        FMT_INFO = 2'b00,
        FMT_SUP  = 2'b01,
        FMT_BAD  = 2'b10,
        FMT_UNN  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SUP_RR  = 2'b00,
        SUP_RNR = 2'b01,
        SUP_R2  = 2'b10,
        SUP_R3  = 2'b11
    } sup_e;

    typedef enum logic [2:0] {
        TX_NONE,
        TX_UA,
        TX_RIM,
        TX_FLOW,
        TX_INFO,
        TX_ACK
    } txsel_e;

    localparam logic [4:0] UTYPE_INIT = 5'b00001;
    localparam logic [4:0] UTYPE_ACK  = 5'b00110;

    typedef struct packed {
        fmt_e       fmt;
        seq_t       ns;
        seq_t       nr;
        sup_e       sup;
        logic [4:0] utype;
    } ctrl_t;

    function automatic logic [7:0] enc_info(seq_t ns, seq_t nr);
        return {nr, ns, 1'b0, 1'b0};
    endfunction

    function automatic logic [7:0] enc_sup(sup_e t, seq_t nr);
        return {nr, 1'b0, t, 2'b01};
    endfunction

    function automatic logic [7:0] enc_unn(logic [4:0] t);
        return {t, 1'b0, 2'b11};
    endfunction

    // forward distance from a to b, modulo the sequence space
    function automatic seq_t seq_dist(seq_t a, seq_t b);
        return b - a;
    endfunction

endpackage

// File: rtl/lce_decode.sv
module lce_decode
    import lce_pkg::*;
(
    input  logic [7:0] ctrl_i,
    output ctrl_t      dec_o
);

    always_comb begin
        dec_o.nr    = ctrl_i[7:5];
        dec_o.ns    = ctrl_i[4:2];
        dec_o.sup   = sup_e'(ctrl_i[3:2]);
        dec_o.utype = ctrl_i[7:3];
        if (!ctrl_i[0]) begin
            dec_o.fmt = FMT_INFO;
        end else if (ctrl_i[1]) begin
            dec_o.fmt = FMT_UNN;
        end else begin
            dec_o.fmt = FMT_SUP;
        end
    end

endmodule

// File: rtl/lce_txbuf.sv
module lce_txbuf
    import lce_pkg::*;
#(
    parameter int PAYLOAD_W = 16
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  seq_t                 wr_idx,
    input  logic [PAYLOAD_W-1:0] wr_data,
    input  seq_t                 rd_idx,
    output logic [PAYLOAD_W-1:0] rd_data
);

    logic [PAYLOAD_W-1:0] rd_vec [SEQ_N];

    for (genvar g = 0; g < SEQ_N; g++) begin : g_slot
        logic [PAYLOAD_W-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == seq_t'(g)) begin
                q <= wr_data;
            end
        end
        assign rd_vec[g] = q;
    end

    assign rd_data = rd_vec[rd_idx];

endmodule

// File: rtl/lce_timer.sv
module lce_timer #(
    parameter int TIMEOUT   = 1000,
    parameter int MAX_RETRY = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic hold,
    input  logic clear,
    output logic expire,
    output logic give_up
);

    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam int RTY_W = $clog2(MAX_RETRY + 1);

    logic [CNT_W-1:0] cnt;
    logic [RTY_W-1:0] tries;
    logic             at_end;

    assign at_end  = (cnt == CNT_W'(TIMEOUT - 1));
    assign expire  = active && !hold && !clear && at_end;
    assign give_up = expire && (tries == RTY_W'(MAX_RETRY));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt   <= '0;
            tries <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (!hold) begin
            if (at_end) begin
                cnt <= '0;
                if (tries != RTY_W'(MAX_RETRY)) begin
                    tries <= tries + 1'b1;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lce_link_ctrl.sv
module lce_link_ctrl
    import lce_pkg::*;
#(
    parameter int PAYLOAD_W = 16,
    parameter int TIMEOUT   = 1000,
    parameter int MAX_RETRY = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 open_req,
    input  logic                 bufs_avail,
    input  logic                 up_tx_valid,
    output logic                 up_tx_ready,
    input  logic [PAYLOAD_W-1:0] up_tx_data,
    output logic                 up_rx_valid,
    output logic [PAYLOAD_W-1:0] up_rx_data,
    output logic                 dn_tx_valid,
    input  logic                 dn_tx_ready,
    output logic [7:0]           dn_tx_ctrl,
    output logic [PAYLOAD_W-1:0] dn_tx_payload,
    input  logic                 dn_rx_valid,
    input  logic [7:0]           dn_rx_ctrl,
    input  logic [PAYLOAD_W-1:0] dn_rx_payload,
    output logic                 link_up,
    output logic                 link_fail
);

    localparam seq_t WIN_MAX = seq_t'(SEQ_N - 1);

    // sequence state: oldest unacked, next to send, next free slot, next expected
    seq_t va, vs, vw, vr, vs_nx;
    logic peer_busy, local_busy, rnr_owed, ack_pend;
    logic ua_pend, rim_pend, awaiting_ua;

    ctrl_t  rxd;
    txsel_e sel;
    sup_e   s_type;
    logic [PAYLOAD_W-1:0] buf_rd;
    logic tmr_expire, tmr_give_up;

    logic rx_unn, rx_rim, rx_ua, opening, rx_live, rx_info, rx_sup;
    logic nr_ok, ack_adv, rx_in_seq, deliver;
    logic flow_owed, i_ready, up_accept, tx_fire, info_fire;

    lce_decode u_dec (
        .ctrl_i (dn_rx_ctrl),
        .dec_o  (rxd)
    );

    // ---------------- receive classification ----------------
    assign rx_unn    = dn_rx_valid && (rxd.fmt == FMT_UNN);
    assign rx_rim    = rx_unn && (rxd.utype == UTYPE_INIT);
    assign rx_ua     = rx_unn && (rxd.utype == UTYPE_ACK) && awaiting_ua;
    assign opening   = rx_rim || rx_ua;
    assign rx_live   = dn_rx_valid && link_up && !opening;
    assign rx_info   = rx_live && (rxd.fmt == FMT_INFO);
    assign rx_sup    = rx_live && (rxd.fmt == FMT_SUP) &&
                       (rxd.sup == SUP_RR || rxd.sup == SUP_RNR);
    assign nr_ok     = seq_dist(va, rxd.nr) <= seq_dist(va, vw);
    assign ack_adv   = (rx_info || rx_sup) && nr_ok && (rxd.nr != va);
    assign rx_in_seq = rx_info && (rxd.ns == vr);
    assign deliver   = rx_in_seq && bufs_avail;

    // ---------------- transmit selection ----------------
    assign flow_owed = rnr_owed || (local_busy && bufs_avail);
    assign i_ready   = link_up && !peer_busy && (vs != vw);
    assign s_type    = bufs_avail ? SUP_RR : SUP_RNR;

    always_comb begin
        if (ua_pend)                    sel = TX_UA;
        else if (rim_pend)              sel = TX_RIM;
        else if (link_up && flow_owed)  sel = TX_FLOW;
        else if (i_ready)               sel = TX_INFO;
        else if (link_up && ack_pend)   sel = TX_ACK;
        else                            sel = TX_NONE;
    end

    always_comb begin
        case (sel)
            TX_UA:           dn_tx_ctrl = enc_unn(UTYPE_ACK);
            TX_RIM:          dn_tx_ctrl = enc_unn(UTYPE_INIT);
            TX_FLOW, TX_ACK: dn_tx_ctrl = enc_sup(s_type, vr);
            TX_INFO:         dn_tx_ctrl = enc_info(vs, vr);
            default:         dn_tx_ctrl = 8'h00;
        endcase
    end

    assign dn_tx_valid   = (sel != TX_NONE);
    assign dn_tx_payload = (sel == TX_INFO) ? buf_rd : '0;
    assign tx_fire       = dn_tx_valid && dn_tx_ready;
    assign info_fire     = tx_fire && (sel == TX_INFO);

    assign up_tx_ready = link_up && !link_fail && (seq_dist(va, vw) != WIN_MAX);
    assign up_accept   = up_tx_valid && up_tx_ready;

    lce_txbuf #(.PAYLOAD_W(PAYLOAD_W)) u_buf (
        .clk     (clk),
        .wr_en   (up_accept),
        .wr_idx  (vw),
        .wr_data (up_tx_data),
        .rd_idx  (vs),
        .rd_data (buf_rd)
    );

    lce_timer #(.TIMEOUT(TIMEOUT), .MAX_RETRY(MAX_RETRY)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .active  (link_up && (va != vs)),
        .hold    (peer_busy),
        .clear   (ack_adv || opening),
        .expire  (tmr_expire),
        .give_up (tmr_give_up)
    );

    // next send pointer: advance on send, skip past acked, rewind on timeout
    always_comb begin
        vs_nx = vs;
        if (info_fire) begin
            vs_nx = vs + 1'b1;
        end
        if (ack_adv && (seq_dist(va, rxd.nr) > seq_dist(va, vs_nx))) begin
            vs_nx = rxd.nr;
        end
        if (tmr_expire) begin
            vs_nx = va;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            va          <= '0;
            vs          <= '0;
            vw          <= '0;
            vr          <= '0;
            peer_busy   <= 1'b0;
            local_busy  <= 1'b0;
            rnr_owed    <= 1'b0;
            ack_pend    <= 1'b0;
            ua_pend     <= 1'b0;
            rim_pend    <= 1'b0;
            awaiting_ua <= 1'b0;
            link_up     <= 1'b0;
            link_fail   <= 1'b0;
            up_rx_valid <= 1'b0;
            up_rx_data  <= '0;
        end else begin
            vs <= vs_nx;
            if (ack_adv) begin
                va <= rxd.nr;
            end
            if (up_accept) begin
                vw <= vw + 1'b1;
            end

            up_rx_valid <= deliver;
            if (deliver) begin
                up_rx_data <= dn_rx_payload;
                vr         <= vr + 1'b1;
            end

            if (open_req && !link_up && !awaiting_ua) begin
                rim_pend <= 1'b1;
            end

            if (tx_fire) begin
                case (sel)
                    TX_UA:  ua_pend <= 1'b0;
                    TX_RIM: begin
                        rim_pend    <= 1'b0;
                        awaiting_ua <= 1'b1;
                    end
                    TX_FLOW, TX_ACK: begin
                        ack_pend   <= 1'b0;
                        rnr_owed   <= 1'b0;
                        local_busy <= !bufs_avail;
                    end
                    TX_INFO: ack_pend <= 1'b0;
                    default: ;
                endcase
            end

            if (rx_sup) begin
                peer_busy <= (rxd.sup == SUP_RNR);
            end
            if (rx_info) begin
                if (rx_in_seq && !bufs_avail) begin
                    rnr_owed <= 1'b1;
                end else begin
                    ack_pend <= 1'b1;
                end
            end

            if (tmr_give_up) begin
                link_fail <= 1'b1;
                link_up   <= 1'b0;
            end

            if (opening) begin
                va          <= '0;
                vs          <= '0;
                vw          <= '0;
                vr          <= '0;
                peer_busy   <= 1'b0;
                local_busy  <= 1'b0;
                rnr_owed    <= 1'b0;
                ack_pend    <= 1'b0;
                rim_pend    <= 1'b0;
                awaiting_ua <= 1'b0;
                link_up     <= 1'b1;
                link_fail   <= 1'b0;
                if (rx_rim) begin
                    ua_pend <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lce_link_ctrl_chk.sv
module lce_link_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       link_up,
    input logic       link_fail,
    input logic       up_tx_ready,
    input logic       up_rx_valid,
    input logic       dn_tx_valid,
    input logic [7:0] dn_tx_ctrl,
    input logic       dn_rx_valid,
    input logic [7:0] dn_rx_ctrl,
    input logic       peer_busy
);

    // R12
    data_frame_needs_link_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_tx_valid && dn_tx_ctrl[1:0] != 2'b11) |-> link_up);

    // R11
    fail_drops_link_chk: assert property (@(posedge clk) disable iff (rst)
        link_fail |-> (!link_up && !up_tx_ready));

    // R9
    no_info_while_peer_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_tx_valid && !dn_tx_ctrl[0]) |-> !peer_busy);

    // R6
    delivery_follows_info_chk: assert property (@(posedge clk) disable iff (rst)
        up_rx_valid |-> $past(dn_rx_valid && !dn_rx_ctrl[0]));

    // R3
    open_follows_unnumbered_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(dn_rx_valid && dn_rx_ctrl[1:0] == 2'b11));

    // R5
    accept_only_when_up_chk: assert property (@(posedge clk) disable iff (rst)
        up_tx_ready |-> link_up);

endmodule

bind lce_link_ctrl lce_link_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_up     (link_up),
    .link_fail   (link_fail),
    .up_tx_ready (up_tx_ready),
    .up_rx_valid (up_rx_valid),
    .dn_tx_valid (dn_tx_valid),
    .dn_tx_ctrl  (dn_tx_ctrl),
    .dn_rx_valid (dn_rx_valid),
    .dn_rx_ctrl  (dn_rx_ctrl),
    .peer_busy   (peer_busy)
);

// File: tb/lce_link_ctrl_tb.sv
`timescale 1ns/1ps
module lce_link_ctrl_tb;

    localparam int PW  = 16;
    localparam int TMO = 40;
    localparam int MR  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          open_req = 1'b0;
    logic          bufs_avail = 1'b1;
    logic          up_tx_valid = 1'b0;
    logic          up_tx_ready;
    logic [PW-1:0] up_tx_data = '0;
    logic          up_rx_valid;
    logic [PW-1:0] up_rx_data;
    logic          dn_tx_valid;
    logic          dn_tx_ready = 1'b0;
    logic [7:0]    dn_tx_ctrl;
    logic [PW-1:0] dn_tx_payload;
    logic          dn_rx_valid = 1'b0;
    logic [7:0]    dn_rx_ctrl = '0;
    logic [PW-1:0] dn_rx_payload = '0;
    logic          link_up;
    logic          link_fail;

    int n_checks = 0;
    int n_fail   = 0;
    int last_wait = 0;

    always #4 clk = ~clk;

    lce_link_ctrl #(.PAYLOAD_W(PW), .TIMEOUT(TMO), .MAX_RETRY(MR)) u_dut (
        .clk(clk), .rst(rst), .open_req(open_req), .bufs_avail(bufs_avail),
        .up_tx_valid(up_tx_valid), .up_tx_ready(up_tx_ready), .up_tx_data(up_tx_data),
        .up_rx_valid(up_rx_valid), .up_rx_data(up_rx_data),
        .dn_tx_valid(dn_tx_valid), .dn_tx_ready(dn_tx_ready), .dn_tx_ctrl(dn_tx_ctrl),
        .dn_tx_payload(dn_tx_payload), .dn_rx_valid(dn_rx_valid), .dn_rx_ctrl(dn_rx_ctrl),
        .dn_rx_payload(dn_rx_payload), .link_up(link_up), .link_fail(link_fail)
    );

    // expected control bytes, built from the requirement field layouts
    function automatic logic [7:0] mk_info(int ns, int nr);
        return 8'(((nr % 8) << 5) | ((ns % 8) << 2));
    endfunction
    function automatic logic [7:0] mk_sup(int typ, int nr);
        return 8'(((nr % 8) << 5) | (typ << 2) | 1);
    endfunction
    function automatic logic [7:0] mk_unn(int typ);
        return 8'((typ << 3) | 3);
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] c, input logic [PW-1:0] p);
        @(negedge clk);
        dn_rx_valid   = 1'b1;
        dn_rx_ctrl    = c;
        dn_rx_payload = p;
        @(negedge clk);
        dn_rx_valid = 1'b0;
    endtask

    task automatic push(input logic [PW-1:0] d);
        int w = 0;
        @(negedge clk);
        up_tx_valid = 1'b1;
        up_tx_data  = d;
        while (!up_tx_ready && w < 300) begin
            @(negedge clk);
            w++;
        end
        @(negedge clk);
        up_tx_valid = 1'b0;
    endtask

    task automatic take(input string tag, input logic [7:0] ec, input bit chk_pl,
                        input logic [PW-1:0] ep);
        int w = 0;
        while (!dn_tx_valid && w < 300) begin
            @(negedge clk);
            w++;
        end
        last_wait = w;
        check({tag, " valid"}, 32'(dn_tx_valid), 32'd1);
        check({tag, " ctrl"}, 32'(dn_tx_ctrl), 32'(ec));
        if (chk_pl) check({tag, " payload"}, 32'(dn_tx_payload), 32'(ep));
        dn_tx_ready = 1'b1;
        @(negedge clk);
        dn_tx_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [PW-1:0] pl [8];
        int exp_ns;
        int exp_vr;
        void'($urandom(32'd1234));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3 reset link_up", 32'(link_up), 0);
        check("R12 reset dn_tx_valid", 32'(dn_tx_valid), 0);
        check("R5 reset up_tx_ready", 32'(up_tx_ready), 0);

        // R12: data frame while down is ignored
        send_frame(mk_info(0, 0), 16'hAAAA);
        check("R12 no delivery while down", 32'(up_rx_valid), 0);
        @(negedge clk);
        check("R12 no ack while down", 32'(dn_tx_valid), 0);

        // R3: open from this side, acknowledge carries the ignored bit 2
        open_req = 1'b1;
        @(negedge clk);
        open_req = 1'b0;
        take("R3 init request", 8'h0B, 1'b0, '0);
        send_frame(mk_unn(6) | 8'h04, '0);
        check("R3 link_up after ack", 32'(link_up), 1);

        // R4: three payloads leave in order
        for (int i = 0; i < 3; i++) begin
            pl[i] = PW'($urandom);
            push(pl[i]);
        end
        for (int i = 0; i < 3; i++) take("R4 info frame", mk_info(i, 0), 1'b1, pl[i]);

        // R5 / R2: ready with bit 4 set releases all three; no resend follows
        send_frame(mk_sup(0, 3) | 8'h10, '0);
        repeat (TMO + 10) @(negedge clk);
        check("R5 no resend after ack", 32'(dn_tx_valid), 0);

        // R6 / R1: in-sequence frame with bit 1 set is delivered
        pl[0] = PW'($urandom);
        send_frame(mk_info(0, 3) | 8'h02, pl[0]);
        check("R6 delivered", 32'(up_rx_valid), 1);
        check("R6 data", 32'(up_rx_data), 32'(pl[0]));
        take("R6 ready ack", mk_sup(0, 1), 1'b0, '0);

        // R7: unexpected ns dropped, ready with unchanged nr
        send_frame(mk_info(3, 3), 16'h5555);
        check("R7 not delivered", 32'(up_rx_valid), 0);
        take("R7 ready", mk_sup(0, 1), 1'b0, '0);

        // R8: no buffers -> not-ready, then ready when they return
        bufs_avail = 1'b0;
        send_frame(mk_info(1, 3), 16'h1111);
        check("R8 dropped", 32'(up_rx_valid), 0);
        take("R8 not-ready", mk_sup(1, 1), 1'b0, '0);
        @(negedge clk);
        check("R8 quiet while busy", 32'(dn_tx_valid), 0);
        bufs_avail = 1'b1;
        take("R8 reopen ready", mk_sup(0, 1), 1'b0, '0);
        pl[1] = PW'($urandom);
        send_frame(mk_info(1, 3), pl[1]);
        check("R8 delivered after reopen", 32'(up_rx_data), 32'(pl[1]));
        take("R8 ack", mk_sup(0, 2), 1'b0, '0);

        // R9: peer not-ready holds back information frames
        send_frame(mk_sup(1, 3), '0);
        pl[2] = PW'($urandom);
        push(pl[2]);
        repeat (10) @(negedge clk);
        check("R9 suppressed", 32'(dn_tx_valid), 0);
        send_frame(mk_sup(0, 3), '0);
        take("R9 released", mk_info(3, 2), 1'b1, pl[2]);

        // R10: no ack -> resend after TIMEOUT
        take("R10 resend 1", mk_info(3, 2), 1'b1, pl[2]);
        check("R10 gap 1", 32'(last_wait >= TMO - 3 && last_wait <= TMO + 3), 1);
        take("R10 resend 2", mk_info(3, 2), 1'b1, pl[2]);
        check("R10 gap 2", 32'(last_wait >= TMO - 3 && last_wait <= TMO + 3), 1);

        // R11: budget spent -> fail
        begin
            int w = 0;
            while (!link_fail && w < TMO + 10) begin
                @(negedge clk);
                w++;
            end
        end
        check("R11 link_fail", 32'(link_fail), 1);
        check("R11 link_up low", 32'(link_up), 0);
        @(negedge clk);
        check("R11 no frames", 32'(dn_tx_valid), 0);
        check("R11 no accept", 32'(up_tx_ready), 0);

        // R3: peer initialize (bit 2 set) reopens, answered with acknowledge
        send_frame(mk_unn(1) | 8'h04, '0);
        check("R3 reopened", 32'(link_up), 1);
        check("R3 fail cleared", 32'(link_fail), 0);
        take("R3 ack reply", 8'h33, 1'b0, '0);

        // R5: window of seven
        for (int i = 0; i < 7; i++) begin
            pl[i] = PW'($urandom);
            push(pl[i]);
        end
        check("R5 window full", 32'(up_tx_ready), 0);
        for (int i = 0; i < 7; i++) take("R5 window frame", mk_info(i, 0), 1'b1, pl[i]);
        send_frame(mk_sup(0, 7), '0);
        check("R5 window reopens", 32'(up_tx_ready), 1);

        // R4 / R6 random phase across the modulo-eight wrap
        exp_ns = 7;
        exp_vr = 0;
        for (int it = 0; it < 24; it++) begin
            logic [PW-1:0] d;
            d = PW'($urandom);
            if ($urandom % 2 == 0) begin
                push(d);
                take("R4 random info", mk_info(exp_ns, exp_vr), 1'b1, d);
                exp_ns = (exp_ns + 1) % 8;
                send_frame(mk_sup(0, exp_ns) | 8'(($urandom % 2) << 4), '0);
            end else begin
                send_frame(mk_info(exp_vr, exp_ns) | 8'(($urandom % 2) << 1), d);
                check("R6 random delivery", 32'(up_rx_data), 32'(d));
                exp_vr = (exp_vr + 1) % 8;
                take("R6 random ack", mk_sup(0, exp_vr), 1'b0, '0);
            end
        end

        summary();
        $finish;
    end

endmodule